// File: doc/BRIEF.md
# Interrupt and Wakeup Control Register

This block is a single 16-bit control and status register that serves one processor core. It collects event requests from three sources: a power-management state-change detector, an audio-codec link port and a general-purpose I/O block. It turns them into sticky pending flags and a shared I/O interrupt line. It also gates a once-per-frame audio interrupt, raises a wakeup request for a powered-down core, and drives a software-controlled core reset.

Software configures the block and services it through a simple synchronous port. A write loads every control field at once. A 1 written to a pending-flag position clears that flag, and a 0 leaves it alone. The audio-link serialiser supplies a tick at the second bit time of slot 12 of each frame, and the block turns that tick into the frame interrupt when the frame enable is set. A separate link-resume event can only wake the core. It never interrupts it.

Top module: `irq_wake_ctl`

## Requirements
- R1: After the synchronous reset, every field reads 0 and `io_irq`, `frame_irq`, `wake_req` and `core_rst` are all low.
- R2: Bit 2 is the soft-reset control. It keeps the value last written. While it is 1 and `core_powered` is high, `core_rst` is high starting one cycle after the write.
- R3: While `core_powered` is low, `core_rst` stays low whatever bit 2 holds. When power returns with bit 2 still set, `core_rst` rises one cycle later.
- R4: Bit 3 enables the frame interrupt. A `frame_tick` pulse gives a one-cycle `frame_irq` pulse on the next cycle when bit 3 is 1, and no pulse at all when bit 3 is 0.
- R5: Bits 8, 9 and 10 are the interrupt enables for power management, the audio port and GPIO. When an enable is 0, an event from that source does not set its pending flag and does not affect `io_irq`.
- R6: Bits 12, 13 and 14 are the pending flags for power management, the audio port and GPIO. Each flag sets on an enabled event. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R7: If an enabled event and a write-1 clear of the same flag occur in the same cycle, the flag stays set. The flag stays set for as long as the event is held.
- R8: `io_irq` is the OR of the three pending flags and changes on the same clock edge as the flags.
- R9: Bits 4, 5 and 6 enable wakeup on power-management, audio-port and GPIO events, and bit 7 enables wakeup on the link-resume event. `wake_req` is high one cycle after an enabled event, and only while `core_powered` is low.
- R10: Bits 0, 1, 11 and 15 read as 0 and ignore writes.
- R11: `rdata` shows the register contents as they stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, taken when `sel` is high |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| core_powered | input | 1 | Core power-up control is set |
| pm_evt | input | 1 | Power-management state-change event |
| aud_evt | input | 1 | Audio-port interrupt event |
| gpio_evt | input | 1 | GPIO interrupt event |
| resume_evt | input | 1 | Audio-link resume event, used for wakeup only |
| frame_tick | input | 1 | Frame position tick from the audio-link serialiser |
| io_irq | output | 1 | Shared I/O interrupt |
| frame_irq | output | 1 | Frame interrupt pulse |
| wake_req | output | 1 | Wakeup request to the power controller |
| core_rst | output | 1 | Soft reset to the core |

## Verification
The pending flags, `io_irq`, `frame_irq`, `wake_req` and the control fields all change on the first clock edge after the stimulus. `core_rst` follows the soft-reset bit one edge later, and `rdata` follows the register one edge later. The bench drives inputs on the falling edge and samples on a falling edge. Each event check reads its output at the first falling edge after the stimulus. Each register check first waits one more edge so that `rdata` has caught up, and the `core_rst` checks wait one edge after the write lands.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int REG_W       = 16;
  localparam int NSRC        = 3;   // 0 power mgmt, 1 audio port, 2 gpio
  localparam int BIT_SRST    = 2;
  localparam int BIT_FRM_EN  = 3;
  localparam int BIT_WEN_LO  = 4;
  localparam int BIT_WEN_RES = BIT_WEN_LO + NSRC;
  localparam int BIT_IEN_LO  = 8;
  localparam int BIT_PEND_LO = 12;
  typedef enum logic [1:0] {SRC_PM = 2'd0, SRC_AUD = 2'd1, SRC_GPIO = 2'd2} src_e;
endpackage

// File: rtl/irq_wake_ctrl_regs.sv
module irq_wake_ctrl_regs
  import irq_wake_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic         srst_d,
  input  logic         frm_en_d,
  input  logic         res_wen_d,
  input  logic [N-1:0] wen_d,
  input  logic [N-1:0] ien_d,
  output logic         srst_q,
  output logic         frm_en_q,
  output logic         res_wen_q,
  output logic [N-1:0] wen_q,
  output logic [N-1:0] ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q    <= 1'b0;
      frm_en_q  <= 1'b0;
      res_wen_q <= 1'b0;
      wen_q     <= '0;
      ien_q     <= '0;
    end else if (wr_stb) begin
      srst_q    <= srst_d;
      frm_en_q  <= frm_en_d;
      res_wen_q <= res_wen_d;
      wen_q     <= wen_d;
      ien_q     <= ien_d;
    end
  end

  // R2: the soft-reset bit holds its value between writes
  p_srst_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(srst_q));
  // R1: the controls are clear after reset
  p_ctrl_reset_r1: assert property (@(posedge clk)
    rst |=> (srst_q == 1'b0 && ien_q == '0 && wen_q == '0));
endmodule

// File: rtl/irq_wake_pending.sv
module irq_wake_pending
  import irq_wake_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ien,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic set_i;
    assign set_i       = evt[i] & ien[i];
    assign pend_nxt[i] = set_i | (pend_q[i] & ~clr[i]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_nxt[i];
    end

    // R7: a set request beats a clear in the same cycle
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && ien[i]) |=> pend_q[i]);
    // R6: a write-1 clear with no set request drops the flag
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !evt[i]) |=> !pend_q[i]);
    // R5: a disabled source never sets its flag
    p_gated_r5: assert property (@(posedge clk) disable iff (rst)
      (!ien[i] && !pend_q[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irq_wake_outputs.sv
module irq_wake_outputs
  import irq_wake_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_nxt,
  input  logic         core_powered,
  input  logic         srst_q,
  input  logic         frm_en_q,
  input  logic         frame_tick,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] wen_q,
  input  logic         res_wen_q,
  input  logic         resume_evt,
  output logic         io_irq,
  output logic         frame_irq,
  output logic         wake_req,
  output logic         core_rst
);
  logic wake_hit;
  assign wake_hit = (|(evt & wen_q)) | (resume_evt & res_wen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      io_irq    <= 1'b0;
      frame_irq <= 1'b0;
      wake_req  <= 1'b0;
      core_rst  <= 1'b0;
    end else begin
      io_irq    <= |pend_nxt;
      frame_irq <= frame_tick & frm_en_q;
      wake_req  <= wake_hit & ~core_powered;
      core_rst  <= srst_q & core_powered;
    end
  end

  // R3: no soft reset reaches an unpowered core
  p_rst_unpowered_r3: assert property (@(posedge clk) disable iff (rst)
    !core_powered |=> !core_rst);
  // R9: a powered core is never asked to wake
  p_wake_powered_r9: assert property (@(posedge clk) disable iff (rst)
    core_powered |=> !wake_req);
  // R4: frame interrupt only with its enable set
  p_frame_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !frm_en_q |=> !frame_irq);
endmodule

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl
  import irq_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             core_powered,
  input  logic             pm_evt,
  input  logic             aud_evt,
  input  logic             gpio_evt,
  input  logic             resume_evt,
  input  logic             frame_tick,
  output logic             io_irq,
  output logic             frame_irq,
  output logic             wake_req,
  output logic             core_rst
);
  logic            wr_stb;
  logic            srst_q, frm_en_q, res_wen_q;
  logic [NSRC-1:0] wen_q, ien_q, pend_q, pend_nxt, evt, clr;
  logic [REG_W-1:0] rd_word;
  logic            unused_rsvd;

  assign wr_stb      = sel & wr_en;
  assign evt         = {gpio_evt, aud_evt, pm_evt};
  assign clr         = {NSRC{wr_stb}} & wdata[BIT_PEND_LO +: NSRC];
  assign unused_rsvd = ^{wdata[1:0], wdata[11], wdata[15]};

  irq_wake_ctrl_regs #(.N(NSRC)) ctrl_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb),
    .srst_d(wdata[BIT_SRST]), .frm_en_d(wdata[BIT_FRM_EN]),
    .res_wen_d(wdata[BIT_WEN_RES]),
    .wen_d(wdata[BIT_WEN_LO +: NSRC]), .ien_d(wdata[BIT_IEN_LO +: NSRC]),
    .srst_q(srst_q), .frm_en_q(frm_en_q), .res_wen_q(res_wen_q),
    .wen_q(wen_q), .ien_q(ien_q)
  );

  irq_wake_pending #(.N(NSRC)) pend_i (
    .clk(clk), .rst(rst), .evt(evt), .ien(ien_q), .clr(clr),
    .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  irq_wake_outputs #(.N(NSRC)) outs_i (
    .clk(clk), .rst(rst), .pend_nxt(pend_nxt), .core_powered(core_powered),
    .srst_q(srst_q), .frm_en_q(frm_en_q), .frame_tick(frame_tick),
    .evt(evt), .wen_q(wen_q), .res_wen_q(res_wen_q), .resume_evt(resume_evt),
    .io_irq(io_irq), .frame_irq(frame_irq), .wake_req(wake_req),
    .core_rst(core_rst)
  );

  always_comb begin
    rd_word                          = '0;
    rd_word[BIT_SRST]                = srst_q;
    rd_word[BIT_FRM_EN]              = frm_en_q;
    rd_word[BIT_WEN_LO +: NSRC]      = wen_q;
    rd_word[BIT_WEN_RES]             = res_wen_q;
    rd_word[BIT_IEN_LO +: NSRC]      = ien_q;
    rd_word[BIT_PEND_LO +: NSRC]     = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  // R8: shared line tracks the pending flags
  p_irq_or_r8: assert property (@(posedge clk) disable iff (rst)
    io_irq == (|pend_q));
  // R10: reserved positions read zero
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rdata[15] == 1'b0 && rdata[11] == 1'b0 && rdata[1:0] == 2'b00));
  // R11: read data trails the register by one edge
  p_rd_lag_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> rdata[BIT_PEND_LO +: NSRC] == $past(pend_q));
endmodule

// File: tb/irq_wake_ctl_tb.sv
module irq_wake_ctl_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic        sel = 0, wr_en = 0, core_powered = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pm_evt = 0, aud_evt = 0, gpio_evt = 0, resume_evt = 0, frame_tick = 0;
  logic        io_irq, frame_irq, wake_req, core_rst;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_wake_ctl dut_i (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .core_powered(core_powered), .pm_evt(pm_evt),
    .aud_evt(aud_evt), .gpio_evt(gpio_evt), .resume_evt(resume_evt),
    .frame_tick(frame_tick), .io_irq(io_irq), .frame_irq(frame_irq),
    .wake_req(wake_req), .core_rst(core_rst)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); sel = 1; wr_en = 1; wdata = v;
    @(negedge clk); sel = 0; wr_en = 0; wdata = '0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); v = rdata;
  endtask

  // 0 pm, 1 audio, 2 gpio, 3 resume, 4 frame tick
  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: pm_evt = 1; 1: aud_evt = 1; 2: gpio_evt = 1; 3: resume_evt = 1; default: frame_tick = 1;
    endcase
    @(negedge clk);
    pm_evt = 0; aud_evt = 0; gpio_evt = 0; resume_evt = 0; frame_tick = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(v);
    check("R1 register", v, 16'h0000);
    check("R1 outputs", {12'h0, io_irq, frame_irq, wake_req, core_rst}, 16'h0);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    core_powered = 0;
    wr(16'hFFFF); rd(v);
    check("R10 reserved read zero", v, 16'h07FC);
    check("R11 read lag", v & 16'h7000, 16'h0000);
    wr(16'h0000); rd(v);
    check("R10 cleared", v, 16'h0000);
  endtask

  task automatic t_srst();
    logic [15:0] v;
    core_powered = 1;
    wr(16'h0004);
    check("R2 rst pending one edge", {15'h0, core_rst}, 16'h0);
    @(negedge clk);
    check("R2 core_rst high", {15'h0, core_rst}, 16'h1);
    repeat (3) @(negedge clk);
    rd(v);
    check("R2 bit held", v, 16'h0004);
    check("R2 core_rst held", {15'h0, core_rst}, 16'h1);
    wr(16'h0000); @(negedge clk);
    check("R2 core_rst released", {15'h0, core_rst}, 16'h0);
  endtask

  task automatic t_srst_unpowered();
    core_powered = 0;
    wr(16'h0004);
    repeat (2) @(negedge clk);
    check("R3 no reset while unpowered", {15'h0, core_rst}, 16'h0);
    core_powered = 1;
    @(negedge clk);
    check("R3 reset on power return", {15'h0, core_rst}, 16'h1);
    wr(16'h0000); @(negedge clk);
  endtask

  task automatic t_frame();
    pulse(4);
    check("R4 disabled no pulse", {15'h0, frame_irq}, 16'h0);
    wr(16'h0008);
    pulse(4);
    check("R4 pulse", {15'h0, frame_irq}, 16'h1);
    @(negedge clk);
    check("R4 one cycle", {15'h0, frame_irq}, 16'h0);
    wr(16'h0000);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    pulse(0); pulse(1); pulse(2);
    check("R5 no irq disabled", {15'h0, io_irq}, 16'h0);
    rd(v);
    check("R5 no flags disabled", v, 16'h0000);
    wr(16'h0400);
    pulse(1);
    check("R5 audio gated", {15'h0, io_irq}, 16'h0);
    pulse(2);
    check("R5 gpio enabled irq", {15'h0, io_irq}, 16'h1);
    rd(v);
    check("R6 gpio flag bit14", v, 16'h4400);
    wr(16'h4000);
    check("R6 cleared irq", {15'h0, io_irq}, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr(16'h0700);
    pulse(0); pulse(1);
    rd(v);
    check("R6 pm and audio flags", v, 16'h3700);
    wr(16'h0700); rd(v);
    check("R6 write 0 no effect", v, 16'h3700);
    wr(16'h2700); rd(v);
    check("R6 audio cleared", v, 16'h1700);
    check("R8 irq with pm left", {15'h0, io_irq}, 16'h1);
    wr(16'h1700);
    check("R8 irq drops with last flag", {15'h0, io_irq}, 16'h0);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    @(negedge clk); gpio_evt = 1; sel = 1; wr_en = 1; wdata = 16'h4700;
    @(negedge clk); gpio_evt = 0; sel = 0; wr_en = 0; wdata = '0;
    check("R7 set beats clear", {15'h0, io_irq}, 16'h1);
    rd(v);
    check("R7 flag kept", v, 16'h4700);
    gpio_evt = 1;
    wr(16'h4700); wr(16'h4700);
    rd(v);
    check("R7 re-arm while held", v, 16'h4700);
    gpio_evt = 0;
    wr(16'h4700); rd(v);
    check("R7 clears after release", v, 16'h0700);
    wr(16'h0000);
  endtask

  task automatic t_wake();
    core_powered = 0;
    wr(16'h0010);
    pulse(1);
    check("R9 audio wake disabled", {15'h0, wake_req}, 16'h0);
    pulse(0);
    check("R9 pm wake", {15'h0, wake_req}, 16'h1);
    @(negedge clk);
    check("R9 wake follows event", {15'h0, wake_req}, 16'h0);
    wr(16'h0080);
    pulse(3);
    check("R9 resume wake bit7", {15'h0, wake_req}, 16'h1);
    wr(16'h00F0);
    core_powered = 1;
    pulse(2);
    check("R9 no wake when powered", {15'h0, wake_req}, 16'h0);
    wr(16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_reserved();
    t_srst();
    t_srst_unpowered();
    t_frame();
    t_gate();
    t_w1c();
    t_setwins();
    t_wake();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule